// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Component Loading

This block holds a 256-entry color lookup table of the kind that sits in front of a video DAC. A host programs it through a narrow register interface. It first writes an entry number to an index register. It then writes the red, green and blue components, in that order, to a single color-data register. The block gathers the three components and writes the whole triple into the entry in one step. Every value the host writes travels in the most significant byte of a 32-bit word, and the lower 24 bits are ignored.

After each completed triple the index advances by one, so a whole palette can be loaded with one index write followed by a stream of component writes. The same index register also selects a small bank of control bytes, at indices 4 to 7, that are loaded through a separate control-data select. The byte at index 4 is a pixel mask that is ANDed with every pixel index before lookup. The byte at index 6 holds an overlay control value, which the block only stores and presents at its outputs.

A pixel port turns an 8-bit pixel index into a 24-bit RGB word. The result appears one clock cycle after the index is presented.

Top module: `clut_write_port`

## Requirements
- R1: The table has 256 entries addressed by an 8-bit index. All host data is taken from bits 31:24 of `wr_data`, and bits 23:0 never affect any state.
- R2: A write with `wr_sel`=0 loads the index register from bits 31:24 and returns the component sequence to red, discarding any partly collected triple.
- R3: With `wr_sel`=1, three writes supply red, green and blue in that order. The entry then reads back as `pix_rgb` = {red[23:16], green[15:8], blue[7:0]}.
- R4: An entry keeps its previous contents until the blue write of its triple, so a lookup never returns a mix of old and new components.
- R5: After each blue write the index register advances by one, wrapping from 255 to 0, and the next component write is taken as red.
- R6: `pix_rgb` shows the entry selected by the `pix_idx` value sampled at the previous rising clock edge, giving one cycle of latency. After reset it is 0.
- R7: A write with `wr_sel`=2 while the index register holds 4, 5, 6 or 7 loads bits 31:24 into control byte k = index-4, which is presented on `ctrl_regs[8k+7:8k]`. After reset byte 0 is 8'hFF and bytes 1 to 3 are 0.
- R8: A write with `wr_sel`=2 while the index register is outside 4 to 7 changes nothing. A `wr_sel`=2 write never changes the index register or the component sequence, and a `wr_sel`=3 write changes nothing at all.
- R9: The entry looked up is `pix_idx` AND control byte 0, the pixel mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per asserted cycle |
| wr_sel | input | 2 | Write target: 0 index, 1 color data, 2 control data, 3 none |
| wr_data | input | 32 | Write word; only bits 31:24 are used |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Registered RGB of the masked pixel index |
| ctrl_regs | output | 32 | Control bytes 0 to 3 (indices 4 to 7) |

## Verification
The bench builds the block with its default parameters: 8-bit index and components, a 32-bit bus, four control bytes starting at index 4, and the read-first collision variant. At this size the full palette can be streamed and read back entry by entry. That reaches every index, the 255-to-0 wrap of the auto-increment, and the control window edges at 3, 4, 7 and 8. The expected colors come from arithmetic functions of the entry number, and the lower bus bits carry junk throughout the run.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      SEL_INDEX = 2'd0,
      SEL_COLOR = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } wsel_e;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int BUS_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [BUS_W-1:0]      wr_data,
   output logic [IDX_W-1:0]      cur_idx,
   output logic                  commit,
   output logic [IDX_W-1:0]      commit_idx,
   output logic [3*COMP_W-1:0]   commit_rgb
);
   localparam int RGB_W = 3 * COMP_W;

   logic [COMP_W-1:0] lane, red_q, grn_q;
   logic [IDX_W-1:0]  idx_q;
   phase_e            phase_q;
   logic              idx_wr, col_wr;

   assign lane   = wr_data[BUS_W-1 -: COMP_W];
   assign idx_wr = wr_en && (wsel_e'(wr_sel) == SEL_INDEX);
   assign col_wr = wr_en && (wsel_e'(wr_sel) == SEL_COLOR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= PH_RED;
         red_q   <= '0;
         grn_q   <= '0;
      end else if (idx_wr) begin
         idx_q   <= wr_data[BUS_W-1 -: IDX_W];
         phase_q <= PH_RED;
      end else if (col_wr) begin
         unique case (phase_q)
            PH_RED: begin red_q <= lane; phase_q <= PH_GRN; end
            PH_GRN: begin grn_q <= lane; phase_q <= PH_BLU; end
            default: begin
               idx_q   <= idx_q + 1'b1;
               phase_q <= PH_RED;
            end
         endcase
      end
   end

   assign commit     = col_wr && (phase_q == PH_BLU);
   assign commit_idx = idx_q;
   assign commit_rgb = {red_q, grn_q, lane};
   assign cur_idx    = idx_q;

   // R5
   addr_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (idx_q == $past(idx_q) + 1'b1) && (phase_q == PH_RED));
   // R2
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (phase_q == PH_RED));
   // R3
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q != phase_e'(2'd3));
   // R8
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2) |=> ($stable(idx_q) && $stable(phase_q)));

   logic unused_ok;
   assign unused_ok = ^{RGB_W};
endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl #(
   parameter int IDX_W     = 8,
   parameter int COMP_W    = 8,
   parameter int CTRL_BASE = 4,
   parameter int CTRL_N    = 4,
   parameter int MASK_SLOT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [IDX_W-1:0]         cur_idx,
   input  logic [COMP_W-1:0]        lane,
   output logic [CTRL_N*COMP_W-1:0] bank
);
   localparam int LAST = CTRL_BASE + CTRL_N - 1;

   for (genvar k = 0; k < CTRL_N; k++) begin : g_slot
      localparam logic [COMP_W-1:0] RST_VAL = (k == MASK_SLOT) ? '1 : '0;
      localparam logic [IDX_W-1:0]  MY_IDX  = IDX_W'(CTRL_BASE + k);
      logic [COMP_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= RST_VAL;
         else if (wr_stb && cur_idx == MY_IDX)
            val_q <= lane;
      end
      assign bank[k*COMP_W +: COMP_W] = val_q;
   end

   // R8
   ctrl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (int'(cur_idx) < CTRL_BASE || int'(cur_idx) > LAST)) |=> $stable(bank));
   // R7
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && int'(cur_idx) >= CTRL_BASE && int'(cur_idx) <= LAST)
      |=> (bank[(int'($past(cur_idx)) - CTRL_BASE)*COMP_W +: COMP_W] == $past(lane)));
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
   parameter int IDX_W       = 8,
   parameter int DATA_W      = 24,
   parameter bit WRITE_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_src;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (WRITE_FIRST) begin : g_wfirst
      assign rd_src = (we && waddr == ridx) ? wdata : mem[ridx];
   end else begin : g_rfirst
      assign rd_src = mem[ridx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_src;
   end

   // R6
   rd_reset_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (rdata == '0));
endmodule

// File: rtl/clut_write_port.sv
module clut_write_port
   import clut_pkg::*;
#(
   parameter int IDX_W       = 8,
   parameter int COMP_W      = 8,
   parameter int BUS_W       = 32,
   parameter int CTRL_BASE   = 4,
   parameter int CTRL_N      = 4,
   parameter int MASK_SLOT   = 0,
   parameter bit WRITE_FIRST = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [BUS_W-1:0]         wr_data,
   input  logic [IDX_W-1:0]         pix_idx,
   output logic [3*COMP_W-1:0]      pix_rgb,
   output logic [CTRL_N*COMP_W-1:0] ctrl_regs
);
   localparam int RGB_W = 3 * COMP_W;

   if (COMP_W > BUS_W || IDX_W > BUS_W) begin : g_bad_lane
      $error("lane wider than bus");
   end
   if (IDX_W > COMP_W) begin : g_bad_mask
      $error("pixel mask narrower than index");
   end
   if (MASK_SLOT >= CTRL_N || CTRL_BASE + CTRL_N > (1 << IDX_W)) begin : g_bad_ctrl
      $error("control window out of range");
   end

   logic [IDX_W-1:0]  cur_idx, commit_idx, look_idx;
   logic              commit, ctrl_stb;
   logic [RGB_W-1:0]  commit_rgb;

   clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_seq (
      .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
      .cur_idx, .commit, .commit_idx, .commit_rgb
   );

   assign ctrl_stb = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

   clut_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W), .CTRL_BASE(CTRL_BASE),
               .CTRL_N(CTRL_N), .MASK_SLOT(MASK_SLOT)) u_ctrl (
      .clk, .rst_n, .wr_stb(ctrl_stb), .cur_idx,
      .lane(wr_data[BUS_W-1 -: COMP_W]), .bank(ctrl_regs)
   );

   assign look_idx = pix_idx & ctrl_regs[MASK_SLOT*COMP_W +: IDX_W];

   clut_ram #(.IDX_W(IDX_W), .DATA_W(RGB_W), .WRITE_FIRST(WRITE_FIRST)) u_ram (
      .clk, .rst_n, .we(commit), .waddr(commit_idx), .wdata(commit_rgb),
      .ridx(look_idx), .rdata(pix_rgb)
   );

   // R4
   commit_only_on_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (wr_en && wr_sel == 2'd1));
endmodule

// File: tb/clut_write_port_bench.sv
module clut_write_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [31:0] wr_data = '0;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;
   logic [31:0] ctrl_regs;

   int n_chk = 0, n_bad = 0, cycles = 0;
   logic [23:0] model [256];

   always #2 clk = ~clk;

   clut_write_port u_clut_write_port (
      .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .pix_idx, .pix_rgb, .ctrl_regs
   );

   function automatic logic [23:0] pat(input int i, input int salt);
      logic [7:0] r, g, b;
      r = 8'((i ^ 8'h5A) + salt);
      g = 8'(i * 3 + salt);
      b = 8'(~i);
      return {r, g, b};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel;
      wr_data = {b, 24'($urandom)};
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = 32'hFFFF_FFFF;
   endtask

   task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
      @(negedge clk);
      pix_idx = idx;
      @(negedge clk);
      chk(req, {8'h0, pix_rgb}, {8'h0, exp});
   endtask

   task automatic triple(input logic [23:0] c);
      wr(2'd1, c[23:16]); wr(2'd1, c[15:8]); wr(2'd1, c[7:0]);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 200000) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=<200000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 R7 reset state
      chk("R6 reset", {8'h0, pix_rgb}, 32'h0);
      chk("R7 reset", ctrl_regs, 32'h0000_00FF);

      // R1 R3 R5 stream the whole table from index 0
      wr(2'd0, 8'd0);
      for (int i = 0; i < 256; i++) begin
         model[i] = pat(i, 0);
         triple(model[i]);
      end
      for (int i = 0; i < 256; i++) look("R1 R3 sweep", 8'(i), model[i]);

      // R5 wrap: start at 255, two triples land at 255 then 0
      wr(2'd0, 8'd255);
      model[255] = pat(255, 7); triple(model[255]);
      model[0]   = pat(0, 9);   triple(model[0]);
      look("R5 wrap 255", 8'd255, model[255]);
      look("R5 wrap 0", 8'd0, model[0]);

      // R4 partial triple leaves entry untouched
      wr(2'd0, 8'd10);
      wr(2'd1, 8'h11); wr(2'd1, 8'h22);
      look("R4 partial", 8'd10, model[10]);
      wr(2'd1, 8'h33);
      model[10] = 24'h112233;
      look("R4 complete", 8'd10, model[10]);

      // R2 index write restarts sequence
      wr(2'd0, 8'd20);
      wr(2'd1, 8'hAA);
      wr(2'd0, 8'd21);
      triple(24'h445566);
      model[21] = 24'h445566;
      look("R2 restart", 8'd21, model[21]);
      look("R2 untouched", 8'd20, model[20]);

      // R6 one cycle latency
      @(negedge clk); pix_idx = 8'd30;
      @(negedge clk); pix_idx = 8'd31;
      #1 chk("R6 latency", {8'h0, pix_rgb}, {8'h0, model[30]});
      @(negedge clk);
      chk("R6 latency next", {8'h0, pix_rgb}, {8'h0, model[31]});

      // R7 control loads at each slot
      for (int k = 0; k < 4; k++) begin
         wr(2'd0, 8'(4 + k));
         wr(2'd2, (k == 0) ? 8'hFF : 8'(8'h70 + k));
      end
      @(negedge clk);
      chk("R7 bank", ctrl_regs, 32'h7372_71FF);

      // R8 out-of-window control writes, and sel 3, ignored
      wr(2'd0, 8'd3);  wr(2'd2, 8'h00);
      wr(2'd0, 8'd8);  wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
      @(negedge clk);
      chk("R8 ignore", ctrl_regs, 32'h7372_71FF);
      look("R8 sel3 table", 8'd8, model[8]);

      // R8 control write keeps index and sequence
      wr(2'd0, 8'd40);
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h99);
      wr(2'd1, 8'h02); wr(2'd1, 8'h03);
      model[40] = 24'h010203;
      look("R8 hold index", 8'd40, model[40]);

      // R9 pixel mask
      wr(2'd0, 8'd4); wr(2'd2, 8'h0F);
      look("R9 mask", 8'h35, model[8'h05]);
      look("R9 mask hi", 8'hF0, model[8'h00]);
      wr(2'd2, 8'hFF);
      look("R9 unmask", 8'h35, model[8'h35]);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule